// File: doc/BRIEF.md
# Masked Event Interrupt Controller

This block collects thirteen hardware event flags into a 32-bit event word and gates them with a 32-bit mask word. Each event flag feeds its own registered, active-high interrupt line. There is no single combined request. An event source raises its flag with a one-cycle pulse on its set input. The flag then stays latched until software clears it by writing a 1 to its bit.

Software reaches both words over a simple register bus: an address, a write enable and write data, with a combinational read return. A write to the transmit-control address also raises the graceful-stop flag at once. The active set is the bitwise AND of the event word and the mask word. A copy of the active set is kept from the previous cycle. Only lines whose active bit differs from that copy are driven to a new level. Every other line keeps its present level.

Top module: `evtIrqCtrl`

## Requirements
- R1: After reset, the event word and the mask word both read 0 and all thirteen interrupt lines are low.
- R2: A pulse on `evtPulse[i]` sets event bit 31-i at the next clock edge. The implemented flags are therefore bits 31 down to 19: heartbeat at 31, babbling receive at 30, babbling transmit at 29, graceful stop at 28, transmit frame at 27, transmit buffer at 26, receive frame at 25, receive buffer at 24, management at 23, bus error at 22, late collision at 21, retry limit at 20 and underrun at 19. Bits 18 to 0 always read 0.
- R3: A write to address 0x004 clears every event bit whose write-data bit is 1 and leaves every bit whose write-data bit is 0 unchanged.
- R4: When a set pulse and a software clear hit the same event bit in the same cycle, the set wins and the bit is 1 afterwards.
- R5: Address 0x008 holds the mask word. All 32 bits are read/write and read back exactly as written.
- R6: Interrupt line i is high one clock after event bit 31-i and mask bit 31-i are both 1. It is low one clock after either of them is 0.
- R7: A write of any data to address 0x0C4 sets event bit 28 (graceful stop) at that clock edge.
- R8: Reads from any address other than 0x004 or 0x008 return 0. Writes to any other address except 0x0C4 change neither word.
- R9: A line whose active bit stays the same from one cycle to the next keeps its level, even while other lines change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 10 | Register byte address |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 32 | Register write data |
| rdData | output | 32 | Register read data, combinational from `regAddr` |
| evtPulse | input | 13 | Event set pulses; bit i sets event bit 31-i |
| irqLines | output | 13 | Interrupt lines; line i follows active bit 31-i |

## Verification
A wrong event or mask bit is visible on `rdData` in the cycle after the faulty edge. It also reaches the matching interrupt line one clock later, so the bench reads the words back and then samples the lines with that one-cycle lag. A stale copy of the previous active set shows up as a line that fails to rise or fall, or that moves while its own active bit is unchanged. The set-versus-clear test and the change-only test are aimed at exactly those errors.

// File: rtl/evtIrqPkg.sv
package evtIrqPkg;
  localparam int NumLines = 13;
  localparam int TopBit   = 31;
  localparam int DataW    = 32;
  localparam int AddrW    = 10;
  localparam int GstopBit = 28;
  localparam logic [AddrW-1:0] EvtAddr   = 10'h004;
  localparam logic [AddrW-1:0] MaskAddr  = 10'h008;
  localparam logic [AddrW-1:0] TxCtlAddr = 10'h0C4;

  typedef struct packed {
    logic wrEvent;
    logic wrMask;
    logic wrTxCtl;
    logic rdEvent;
    logic rdMask;
  } regStrobe_t;
endpackage

// File: rtl/evtRegDecode.sv
module evtRegDecode
  import evtIrqPkg::*;
#(
  parameter int ADDR_W = AddrW
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  output regStrobe_t        stb
);
  logic hitEvt, hitMask, hitTx;

  always_comb begin
    hitEvt  = (regAddr == ADDR_W'(EvtAddr));
    hitMask = (regAddr == ADDR_W'(MaskAddr));
    hitTx   = (regAddr == ADDR_W'(TxCtlAddr));
    stb.wrEvent = wrEn & hitEvt;
    stb.wrMask  = wrEn & hitMask;
    stb.wrTxCtl = wrEn & hitTx;
    stb.rdEvent = hitEvt;
    stb.rdMask  = hitMask;
  end
endmodule

// File: rtl/evtRegFile.sv
module evtRegFile
  import evtIrqPkg::*;
#(
  parameter int DATA_W    = DataW,
  parameter int NUM_LINES = NumLines,
  parameter int TOP_BIT   = TopBit,
  parameter int GSTOP_BIT = GstopBit
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  regStrobe_t           stb,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [NUM_LINES-1:0] evtPulse,
  output logic [NUM_LINES-1:0] activeLines,
  output logic [DATA_W-1:0]    rdData
);
  logic [NUM_LINES-1:0] evtQ, evtD, clrLines, setLines;
  logic [DATA_W-1:0]    maskQ, eventWord;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    assign clrLines[i] = stb.wrEvent & wrData[TOP_BIT-i];
    if (TOP_BIT - i == GSTOP_BIT) begin : g_gstop
      assign setLines[i] = evtPulse[i] | stb.wrTxCtl;
    end else begin : g_plain
      assign setLines[i] = evtPulse[i];
    end
    assign activeLines[i] = evtQ[i] & maskQ[TOP_BIT-i];
  end

  always_comb begin
    eventWord = '0;
    for (int i = 0; i < NUM_LINES; i++) eventWord[TOP_BIT-i] = evtQ[i];
  end

  assign evtD = (evtQ & ~clrLines) | setLines;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtQ  <= '0;
      maskQ <= '0;
    end else begin
      evtQ <= evtD;
      if (stb.wrMask) maskQ <= wrData;
    end
  end

  assign rdData = stb.rdEvent ? eventWord : (stb.rdMask ? maskQ : '0);

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (|evtPulse) |=> ((evtQ & $past(evtPulse)) == $past(evtPulse))); // R4
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrEvent && evtPulse == '0) |=> ((eventWord & $past(wrData)) == '0)); // R3
  AST_MASK_STORE: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrMask |=> (maskQ == $past(wrData))); // R5
  AST_GSTOP_SET: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrTxCtl |=> eventWord[GSTOP_BIT]); // R7
endmodule

// File: rtl/irqLineDrive.sv
module irqLineDrive
  import evtIrqPkg::*;
#(
  parameter int NUM_LINES = NumLines
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] activeLines,
  output logic [NUM_LINES-1:0] irqLines
);
  logic [NUM_LINES-1:0] prevActive, changed, irqQ;

  assign changed = activeLines ^ prevActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevActive <= '0;
      irqQ       <= '0;
    end else begin
      prevActive <= activeLines;
      for (int i = 0; i < NUM_LINES; i++)
        if (changed[i]) irqQ[i] <= activeLines[i];
    end
  end

  assign irqLines = irqQ;

  AST_LINE_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqLines == $past(activeLines))); // R6
  AST_LINE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    $stable(activeLines) |=> $stable(irqLines)); // R9
endmodule

// File: rtl/evtIrqCtrl.sv
module evtIrqCtrl
  import evtIrqPkg::*;
#(
  parameter int ADDR_W    = AddrW,
  parameter int DATA_W    = DataW,
  parameter int NUM_LINES = NumLines
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 wrEn,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  input  logic [NUM_LINES-1:0] evtPulse,
  output logic [NUM_LINES-1:0] irqLines
);
  regStrobe_t           stb;
  logic [NUM_LINES-1:0] activeLines;

  evtRegDecode #(.ADDR_W(ADDR_W)) uDecode (
    .regAddr(regAddr), .wrEn(wrEn), .stb(stb));

  evtRegFile #(.DATA_W(DATA_W), .NUM_LINES(NUM_LINES)) uRegs (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .evtPulse(evtPulse), .activeLines(activeLines), .rdData(rdData));

  irqLineDrive #(.NUM_LINES(NUM_LINES)) uLines (
    .clk(clk), .rstN(rstN), .activeLines(activeLines), .irqLines(irqLines));

  AST_RESET_QUIET: assert property (@(posedge clk) !rstN |=> irqLines == '0); // R1
endmodule

// File: tb/sim_evtIrqCtrl.sv
module sim_evtIrqCtrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [9:0]  regAddr = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [12:0] evtPulse = '0;
  logic [12:0] irqLines;

  int total = 0;
  int bad = 0;

  evtIrqCtrl u0 (.clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .evtPulse(evtPulse), .irqLines(irqLines));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeReg(logic [9:0] a, logic [31:0] d);
    @(negedge clk);
    regAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic readReg(logic [9:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic pulse(logic [12:0] p);
    @(negedge clk);
    evtPulse = p;
    @(negedge clk);
    evtPulse = '0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic testReset();
    logic [31:0] v;
    readReg(10'h004, v); check("R1 event", v, 32'h0);
    readReg(10'h008, v); check("R1 mask", v, 32'h0);
    check("R1 lines", {19'h0, irqLines}, 32'h0);
  endtask

  task automatic testMask();
    logic [31:0] v;
    writeReg(10'h008, 32'hFFFF_FFFF);
    readReg(10'h008, v); check("R5 all ones", v, 32'hFFFF_FFFF);
    writeReg(10'h008, 32'hA5A5_5A5A);
    readReg(10'h008, v); check("R5 pattern", v, 32'hA5A5_5A5A);
    writeReg(10'h008, 32'h0);
  endtask

  task automatic testEachEvent();
    logic [31:0] v;
    int errs = 0;
    for (int i = 0; i < 13; i++) begin
      pulse(13'h1 << i);
      readReg(10'h004, v);
      if (v !== (32'h1 << (31 - i))) errs++;
      writeReg(10'h004, 32'hFFFF_FFFF);
      readReg(10'h004, v);
      if (v !== 32'h0) errs++;
    end
    check("R2 per-bit positions", errs, 0);
    pulse(13'h1FFF);
    readReg(10'h004, v); check("R2 all flags, low bits zero", v, 32'hFFF8_0000);
  endtask

  task automatic testW1C();
    logic [31:0] v;
    writeReg(10'h004, 32'h0F00_0000);
    readReg(10'h004, v); check("R3 partial clear", v, 32'hF0F8_0000);
    writeReg(10'h004, 32'h0);
    readReg(10'h004, v); check("R3 zero write keeps", v, 32'hF0F8_0000);
    writeReg(10'h004, 32'hFFFF_FFFF);
    readReg(10'h004, v); check("R3 full clear", v, 32'h0);
  endtask

  task automatic testSetWins();
    logic [31:0] v;
    @(negedge clk);
    regAddr = 10'h004; wrData = 32'hFFFF_FFFF; wrEn = 1'b1; evtPulse = 13'h0020;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0; evtPulse = '0;
    readReg(10'h004, v); check("R4 set beats clear", v, 32'h0400_0000);
    writeReg(10'h004, 32'hFFFF_FFFF);
  endtask

  task automatic testLines();
    logic [31:0] v;
    pulse(13'h1FFF);
    step();
    check("R6 masked off", {19'h0, irqLines}, 32'h0);
    writeReg(10'h008, 32'h8008_0000);
    check("R6 not before one clock", {19'h0, irqLines}, 32'h0);
    step();
    check("R6 lines 0 and 12", {19'h0, irqLines}, 32'h0000_1001);
    writeReg(10'h004, 32'h8000_0000);
    step();
    check("R9 line 12 holds, line 0 drops", {19'h0, irqLines}, 32'h0000_1000);
    writeReg(10'h008, 32'h0);
    step();
    check("R6 mask off drops", {19'h0, irqLines}, 32'h0);
    writeReg(10'h004, 32'hFFFF_FFFF);
    readReg(10'h004, v); check("R3 cleanup", v, 32'h0);
  endtask

  task automatic testGracefulStop();
    logic [31:0] v;
    writeReg(10'h008, 32'h1000_0000);
    writeReg(10'h0C4, 32'h0);
    readReg(10'h004, v); check("R7 graceful stop flag", v, 32'h1000_0000);
    step();
    check("R7 line 3 raised", {19'h0, irqLines}, 32'h0000_0008);
    writeReg(10'h004, 32'hFFFF_FFFF);
    writeReg(10'h008, 32'h0);
  endtask

  task automatic testOtherAddr();
    logic [31:0] v;
    pulse(13'h0001);
    writeReg(10'h008, 32'h1234_5678);
    writeReg(10'h100, 32'hFFFF_FFFF);
    readReg(10'h100, v); check("R8 unmapped reads zero", v, 32'h0);
    readReg(10'h004, v); check("R8 event untouched", v, 32'h8000_0000);
    readReg(10'h008, v); check("R8 mask untouched", v, 32'h1234_5678);
  endtask

  logic done = 1'b0;

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 3);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testMask();
    testEachEvent();
    testW1C();
    testSetWins();
    testLines();
    testGracefulStop();
    testOtherAddr();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule